// File: doc/BRIEF.md
# Cache-Line Block Copy Engine

This block copies a whole number of cache lines from one memory region to another, or fills a destination region with zeros without reading anything. Software sets up a source, a destination and an optional notification address through a small register interface. It then starts the job with one write to the control register. That write carries the start flag, the mode bits and the line count.

The engine moves data over a line-wide memory port. Each request is held until the memory answers with an acknowledge. The acknowledge may carry an error flag and a one-hot cause code. A failed response stops the job, and the cause is kept in the status word. When notification is requested, the final status word is written to the notification address before the engine goes idle.

Top module: `line_copy_engine`

## Requirements
- R1: After reset the status word reads zero and no memory request is raised.
- R2: Register index 0 is control/status, 1 is source, 2 is destination and 3 is notification address. Indices 1 to 3 read back the last value written, with the address bits below the line size (4 bits at 16-byte lines) read as zero.
- R3: A write to index 0 with bit 16 set, made while idle, starts a job. Bits 15:0 give the line count, bit 24 selects zero-fill and bit 28 requests notification, and the write clears any earlier error. Status bit 16 (busy) stays set for the whole job.
- R4: In copy mode every line is read from the source and then written to the destination, in ascending line order. Address bits below the line size are driven as zero.
- R5: Status bits 15:0 hold the remaining line count, which drops by one after each successful line write.
- R6: In zero-fill mode the engine issues only destination writes, with all-zero data, and never reads.
- R7: A memory request keeps its address, direction and data unchanged until it is acknowledged.
- R8: With notification set, the engine ends a job by writing the final status word (busy clear) into bits 63:0 of a line write to the notification address. Busy clears after that write is acknowledged. An error on this write is ignored.
- R9: An acknowledge with the error flag set on a data request ends the job. No further data request is issued. The one-hot cause is stored in status bits 41:36 and status bit 17 (error) is set.
- R10: The error bit and cause stay unchanged until the next start write.
- R11: A start write made while busy has no effect. A write to index 0 with bit 16 clear has no effect.
- R12: A line count of zero issues no data request. It posts only the notification write when notification is requested, and otherwise finishes at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Line-aligned byte address |
| mem_wdata | output | 8*LINE_BYTES | Write data |
| mem_ack | input | 1 | Response for the pending request |
| mem_err | input | 1 | Response carries an error |
| mem_ecode | input | 6 | One-hot error cause |
| mem_rdata | input | 8*LINE_BYTES | Read data |

## Verification
On every cycle the assertions check four things: requests stay stable until acknowledged, zero-fill never reads, the remaining count steps down on each write, and an error response captures its cause and stops data traffic. They also check that the error flag holds and that start writes made while busy leave the mode alone. The bench's memory model compares each request with a queue computed from the job parameters. Only its scenarios show the request order, the copied contents, the notification word, zero-length jobs, ignored control writes and register read-back.

// File: rtl/line_copy_engine.sv
module line_copy_engine #(
  parameter int ADDR_W     = 48,
  parameter int LINE_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [1:0]              reg_addr,
  input  logic [63:0]             reg_wdata,
  output logic [63:0]             reg_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [8*LINE_BYTES-1:0] mem_wdata,
  input  logic                    mem_ack,
  input  logic                    mem_err,
  input  logic [5:0]              mem_ecode,
  input  logic [8*LINE_BYTES-1:0] mem_rdata
);
  localparam int OFS    = $clog2(LINE_BYTES);
  localparam int LINE_W = 8 * LINE_BYTES;
  localparam int LA_W   = ADDR_W - OFS;

  typedef enum logic [1:0] {IDLE, RD, WR, NTF} st_t;
  st_t st;

  logic [LA_W-1:0]   src_q, dst_q, ntf_q, cur_src, cur_dst;
  logic [15:0]       len_q;
  logic              zf_q, nt_q, err_q;
  logic [5:0]        ecode_q;
  logic [LINE_W-1:0] line_q;
  logic [63:0]       status;

  wire busy     = (st != IDLE);
  wire start_wr = reg_we && (reg_addr == 2'd0) && reg_wdata[16];
  wire start    = start_wr && !busy;
  wire data_ph  = (st == RD) || (st == WR);

  assign status = {22'd0, ecode_q, 7'd0, nt_q, 3'd0, zf_q, 6'd0, err_q, busy, len_q};

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = status;
      2'd1:    reg_rdata = {{(64-ADDR_W){1'b0}}, src_q, {OFS{1'b0}}};
      2'd2:    reg_rdata = {{(64-ADDR_W){1'b0}}, dst_q, {OFS{1'b0}}};
      default: reg_rdata = {{(64-ADDR_W){1'b0}}, ntf_q, {OFS{1'b0}}};
    endcase
  end

  assign mem_req  = busy;
  assign mem_we   = (st != RD);
  assign mem_addr = {(st == RD) ? cur_src : (st == WR) ? cur_dst : ntf_q, {OFS{1'b0}}};
  assign mem_wdata = (st == NTF) ? {{(LINE_W-64){1'b0}}, status & ~64'h1_0000}
                   : (st == WR && !zf_q) ? line_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      src_q <= '0; dst_q <= '0; ntf_q <= '0;
      cur_src <= '0; cur_dst <= '0;
      len_q <= '0; zf_q <= 1'b0; nt_q <= 1'b0;
      err_q <= 1'b0; ecode_q <= '0; line_q <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          2'd1: src_q <= reg_wdata[ADDR_W-1:OFS];
          2'd2: dst_q <= reg_wdata[ADDR_W-1:OFS];
          2'd3: ntf_q <= reg_wdata[ADDR_W-1:OFS];
          default: ;
        endcase
      end
      case (st)
        IDLE: if (start) begin
          len_q   <= reg_wdata[15:0];
          zf_q    <= reg_wdata[24];
          nt_q    <= reg_wdata[28];
          err_q   <= 1'b0;
          ecode_q <= '0;
          cur_src <= src_q;
          cur_dst <= dst_q;
          if (reg_wdata[15:0] == 16'd0) st <= reg_wdata[28] ? NTF : IDLE;
          else                          st <= reg_wdata[24] ? WR : RD;
        end
        RD, WR: if (mem_ack) begin
          if (mem_err) begin
            err_q   <= 1'b1;
            ecode_q <= mem_ecode;
            st      <= nt_q ? NTF : IDLE;
          end else if (st == RD) begin
            line_q <= mem_rdata;
            st     <= WR;
          end else begin
            len_q   <= len_q - 16'd1;
            cur_src <= cur_src + 1'b1;
            cur_dst <= cur_dst + 1'b1;
            if (len_q == 16'd1) st <= nt_q ? NTF : IDLE;
            else                st <= zf_q ? WR : RD;
          end
        end
        NTF: if (mem_ack) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R6
  zf_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && zf_q |-> !(mem_req && !mem_we));

  // R5
  len_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WR) && mem_ack && !mem_err |=> len_q == $past(len_q) - 16'd1);

  // R9
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_ph && mem_ack && mem_err |=> err_q && (ecode_q == $past(mem_ecode)) && !data_ph);

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !start |=> err_q && $stable(ecode_q));

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start_wr |=> $stable(zf_q) && $stable(nt_q));
endmodule

// File: tb/line_copy_engine_bench.sv
module line_copy_engine_bench;
  localparam int AW = 48;
  localparam int LB = 16;
  localparam int LW = 8 * LB;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [63:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [LW-1:0] mem_wdata, mem_rdata = 0;
  logic mem_ack = 0, mem_err = 0;
  logic [5:0] mem_ecode = 0;

  line_copy_engine #(.ADDR_W(AW), .LINE_BYTES(LB)) u_line_copy_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_ecode(mem_ecode),
    .mem_rdata(mem_rdata));

  always #10 clk = ~clk;

  int total = 0, fails = 0;
  logic [LW-1:0] mem_m [longint];
  longint eq_addr[$];
  bit eq_we[$];
  logic [LW-1:0] eq_data[$];
  int err_at = -1, req_idx = 0, lat = 0;
  bit ack_was = 0;
  logic [5:0] err_code = 0;
  logic [63:0] exp_stat;

  task automatic chk(bit ok, string req, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] rd_line(longint a);
    if (mem_m.exists(a)) return mem_m[a];
    return {4{a[31:0] ^ 32'h5A5A_0F0F}};
  endfunction

  always @(negedge clk) begin
    mem_ack = 0; mem_err = 0; mem_ecode = 0;
    if (ack_was) ack_was = 0;
    else if (rst_n && mem_req) begin
      if (lat < 1) lat++;
      else begin
        lat = 0;
        if (eq_addr.size() == 0) begin
          chk(0, "R4", "unexpected request", LW'(mem_addr), '0);
        end else begin
          chk(mem_addr == eq_addr[0] && mem_we == eq_we[0], "R4", "request addr/dir",
              {mem_we, LW'(mem_addr)}, {eq_we[0], LW'(eq_addr[0])});
          if (mem_we) chk(mem_wdata == eq_data[0], "R6 R8", "write data", mem_wdata, eq_data[0]);
          void'(eq_addr.pop_front()); void'(eq_we.pop_front()); void'(eq_data.pop_front());
        end
        if (req_idx == err_at) begin
          mem_err = 1; mem_ecode = err_code;
        end else if (mem_we) mem_m[longint'(mem_addr >> 4)] = mem_wdata;
        else mem_rdata = rd_line(longint'(mem_addr >> 4));
        mem_ack = 1; ack_was = 1; req_idx++;
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [63:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_addr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [63:0] d);
    reg_addr = a; #1 d = reg_rdata; reg_addr = 0;
  endtask

  task automatic prep(longint src, longint dst, longint ntf, int len, bit zf, bit nt, int eat, logic [5:0] code);
    int k = 0, done = 0;
    bit ab = 0;
    longint s = src >> 4, d = dst >> 4;
    wr(1, src); wr(2, dst); wr(3, ntf);
    for (int i = 0; i < len && !ab; i++) begin
      if (!zf) begin
        eq_addr.push_back((s + i) << 4); eq_we.push_back(0); eq_data.push_back('0);
        if (k == eat) ab = 1;
        k++;
      end
      if (!ab) begin
        eq_addr.push_back((d + i) << 4); eq_we.push_back(1);
        eq_data.push_back(zf ? '0 : rd_line(s + i));
        if (k == eat) ab = 1; else done++;
        k++;
      end
    end
    exp_stat = {22'd0, ab ? code : 6'd0, 7'd0, nt, 3'd0, zf, 6'd0, ab, 1'b0, 16'(len - done)};
    if (nt) begin
      eq_addr.push_back((ntf >> 4) << 4); eq_we.push_back(1); eq_data.push_back(LW'(exp_stat));
    end
    err_at = eat; err_code = code; req_idx = 0;
  endtask

  function automatic logic [63:0] ctl(int len, bit zf, bit nt);
    return 64'h1_0000 | (64'(zf) << 24) | (64'(nt) << 28) | 64'(len[15:0]);
  endfunction

  task automatic finish_job(string req);
    logic [63:0] s;
    int n = 0;
    rd(0, s);
    while (s[16] && n < 3000) begin @(negedge clk); rd(0, s); n++; end
    chk(s == exp_stat, req, "final status", LW'(s), LW'(exp_stat));
    chk(eq_addr.size() == 0, req, "requests left", LW'(eq_addr.size()), '0);
    eq_addr.delete(); eq_we.delete(); eq_data.delete();
  endtask

  initial begin
    #4_000_000;
    total++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [63:0] s;
    repeat (3) @(negedge clk);
    rd(0, s);
    chk(s == 0 && !mem_req, "R1", "reset state", LW'({mem_req, s}), '0);
    rst_n = 1;
    @(negedge clk);

    wr(1, 64'h1234_5678_9ABF); rd(1, s);
    chk(s == 64'h1234_5678_9AB0, "R2", "source readback", LW'(s), LW'(64'h1234_5678_9AB0));
    wr(3, 64'h0000_0000_7007); rd(3, s);
    chk(s == 64'h7000, "R2", "notify readback", LW'(s), LW'(64'h7000));

    // R3 R4 R5: copy of 3 lines, unaligned low bits ignored
    prep(64'h1000 + 5, 64'h8000, 64'h7000, 3, 0, 0, -1, 0);
    wr(0, ctl(3, 0, 0)); rd(0, s);
    chk(s[16] == 1, "R3", "busy during job", LW'(s[16]), 1);
    finish_job("R5");
    chk(mem_m[64'h800] == rd_line(64'h100) && mem_m[64'h802] == rd_line(64'h102), "R4",
        "dest contents", mem_m[64'h802], rd_line(64'h102));

    // R6 R8: zero-fill with notify
    prep(64'h2000, 64'h9000, 64'h7000, 2, 1, 1, -1, 0);
    wr(0, ctl(2, 1, 1));
    finish_job("R8");
    chk(mem_m[64'h901] == 0, "R6", "zero fill", mem_m[64'h901], '0);

    // R11: start while busy
    prep(64'h3000, 64'hA000, 64'h7000, 4, 0, 0, -1, 0);
    wr(0, ctl(4, 0, 0));
    repeat (3) @(negedge clk);
    wr(0, ctl(9, 1, 1));
    finish_job("R11");

    // R12: zero length, with and without notify
    prep(64'h3000, 64'hA000, 64'h7100, 0, 0, 1, -1, 0);
    wr(0, ctl(0, 0, 1));
    finish_job("R12");
    prep(64'h3000, 64'hA000, 64'h7100, 0, 0, 0, -1, 0);
    wr(0, ctl(0, 0, 0));
    finish_job("R12");

    // R9: error on the write of line 1, notify set
    prep(64'h4000, 64'hB000, 64'h7200, 4, 0, 1, 3, 6'h08);
    wr(0, ctl(4, 0, 1));
    finish_job("R9");

    // R10 R11: error held, control write without start bit ignored
    repeat (5) @(negedge clk);
    wr(0, 64'h0000_0000_1000_0005);
    repeat (4) @(negedge clk);
    rd(0, s);
    chk(s == exp_stat && !mem_req, "R10", "error held, no-start write ignored", LW'(s), LW'(exp_stat));

    // R9: timeout in zero-fill without notify
    prep(64'h0, 64'hC000, 64'h7000, 5, 1, 0, 2, 6'h10);
    wr(0, ctl(5, 1, 0));
    finish_job("R9");

    // R10: new start clears error
    prep(64'h5000, 64'hD000, 64'h7000, 1, 0, 0, -1, 0);
    wr(0, ctl(1, 0, 0));
    finish_job("R10");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule